// File: doc/BRIEF.md
# Timer-Driven PWM Carrier Generator

This block produces a fixed-frequency pulse-width-modulated carrier on one output pin, such as the roughly 38 kHz carrier that modulates an infrared LED. A free-running 8-bit up-counter is clocked through a selectable prescaler and restarts after reaching a programmable period value. A 10-bit duty value is compared against the counter extended by a 2-bit sub-tick count. The comparison therefore resolves a quarter of a counter tick, and full-scale duty is four times the period length.

The surrounding logic holds three configuration values and presents them on the ports. The first is an 8-bit period. The second is the upper 8 bits of the duty value. The third is a 4-bit control word: bits [3:2] carry the two low duty bits and bits [1:0] carry the mode code. Duty writes go into a shadow register and take effect only at a period boundary. Clearing the control word drives the pin low on the next clock, whatever level it had. Each assertion of `tick_i` is one quarter-step of base time, subject to the prescaler and the timer run bit.

Top module: `pwm_carrier`

## Requirements
- R1: The timer counts up from 0. After it reaches `period_i` with sub-tick 3, it restarts at 0. One carrier period therefore lasts 4*(period_i+1) prescaled steps.
- R2: `presc_sel_i` sets the prescale ratio: code 0 gives 1:1, code 1 gives 1:4, and codes 2 and 3 give 1:16. A prescaled step occurs once per that many cycles in which `tick_i` and `tmr_run_i` are both high.
- R3: The duty value is {`duty_hi_i`, `ctrl_i[3:2]`}, 10 bits wide. The output is high while {timer, sub-tick} is below the duty value. It goes high at the start of each period and goes low when the position equals the duty value.
- R4: A duty value of 0 keeps the output low for the whole period. A duty value of at least 4*(period_i+1) keeps it high for the whole period.
- R5: PWM runs only when the mode code `ctrl_i[1:0]` is 2'b11. Any other code, including an all-zero control word, forces `pwm_o` low on the next clock edge.
- R6: While PWM runs, a change to the duty value takes effect only at the next period rollover. While PWM is off, the shadow follows the inputs.
- R7: When `tick_i` or `tmr_run_i` is low, the timer does not advance and the output level is held.
- R8: While `rst_ni` is low, `pwm_o` is low and the timer is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base time enable, one quarter-step per pulse |
| tmr_run_i | input | 1 | Timer run bit |
| presc_sel_i | input | 2 | Prescaler code: 0 for 1:1, 1 for 1:4, 2 or 3 for 1:16 |
| period_i | input | 8 | Period value; the timer restarts after reaching it |
| duty_hi_i | input | 8 | Upper 8 bits of the duty value |
| ctrl_i | input | 4 | [3:2] low duty bits, [1:0] mode code (2'b11 selects PWM) |
| pwm_o | output | 1 | Carrier output |

## Verification
Two events can fall on the same edge: a period rollover and a duty update. The bench provokes this by synchronising on a rising output edge, which marks position 0. It then writes a new duty value at once, so the shadow must hold the old value through that period and load the new value on the same edge that wraps the timer. The bench judges the result by counting high samples. The period with the old value must show the old duty, and the next period must show the new duty, with no partial value in either.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PSC_W = 4;
  localparam logic [1:0] MODE_PWM = 2'b11;

  typedef enum logic [1:0] {
    PSC_1   = 2'd0,
    PSC_4   = 2'd1,
    PSC_16  = 2'd2,
    PSC_16B = 2'd3
  } psc_sel_e;

  function automatic logic [PSC_W-1:0] psc_limit(psc_sel_e sel);
    case (sel)
      PSC_1:   return PSC_W'(0);
      PSC_4:   return PSC_W'(3);
      default: return PSC_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] limit;
  logic             live;

  assign limit  = psc_limit(psc_sel_e'(sel_i));
  assign live   = tick_i & run_i;
  // >= so a ratio change mid-count cannot strand the counter
  assign step_o = live & (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (live) cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  localparam int POS_W = PER_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [PER_W-1:0] period_i,
  output logic [POS_W-1:0] pos_q_o,
  output logic [POS_W-1:0] pos_d_o,
  output logic             wrap_o
);
  logic [PER_W-1:0] tmr_q, tmr_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             sub_last;

  assign sub_last = &sub_q;
  assign wrap_o   = step_i & sub_last & (tmr_q == period_i);

  always_comb begin
    sub_d = sub_q;
    tmr_d = tmr_q;
    if (step_i) begin
      sub_d = sub_q + 1'b1;
      if (sub_last) tmr_d = wrap_o ? '0 : tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      sub_q <= '0;
    end else begin
      tmr_q <= tmr_d;
      sub_q <= sub_d;
    end
  end

  assign pos_q_o = {tmr_q, sub_q};
  assign pos_d_o = {tmr_d, sub_d};

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> pos_q_o == '0);
  p_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !wrap_o) |=> pos_q_o == POS_W'($past(pos_q_o) + 1'b1));
  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q_o));
endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow #(
  parameter int DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] sh_q_o,
  output logic [DUTY_W-1:0] sh_d_o
);
  logic [DUTY_W-1:0] sh_q;

  assign sh_d_o = load_i ? duty_i : sh_q;
  assign sh_q_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d_o;
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(sh_q));
  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q == $past(duty_i));
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [POS_W-1:0] pos_d_i,
  input  logic [POS_W-1:0] duty_d_i,
  output logic             pwm_o
);
  logic pwm_q;

  // registered against next-state position and duty: glitch-free pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= en_i & (pos_d_i < duty_d_i);
  end

  assign pwm_o = pwm_q;

  p_off_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import pwm_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  localparam int DUTY_W = PER_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tmr_run_i,
  input  logic [1:0]       presc_sel_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] duty_hi_i,
  input  logic [SUB_W+1:0] ctrl_i,
  output logic             pwm_o
);
  logic              step;
  logic              wrap;
  logic              pwm_en;
  logic [DUTY_W-1:0] duty_in;
  logic [DUTY_W-1:0] pos_q, pos_d;
  logic [DUTY_W-1:0] sh_q, sh_d;

  assign pwm_en  = (ctrl_i[1:0] == MODE_PWM);
  assign duty_in = {duty_hi_i, ctrl_i[SUB_W+1:2]};

  pwm_prescaler u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .run_i  (tmr_run_i),
    .sel_i  (presc_sel_i),
    .step_o (step)
  );

  pwm_timebase #(.PER_W(PER_W), .SUB_W(SUB_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .period_i (period_i),
    .pos_q_o  (pos_q),
    .pos_d_o  (pos_d),
    .wrap_o   (wrap)
  );

  // shadow tracks inputs while off, else loads only at rollover
  pwm_duty_shadow #(.DUTY_W(DUTY_W)) u_sh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap | ~pwm_en),
    .duty_i (duty_in),
    .sh_q_o (sh_q),
    .sh_d_o (sh_d)
  );

  pwm_out_stage #(.POS_W(DUTY_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pwm_en),
    .pos_d_i  (pos_d),
    .duty_d_i (sh_d),
    .pwm_o    (pwm_o)
  );

  p_zero_duty_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_q == '0) |-> !pwm_o);
  p_at_duty_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q >= sh_q) |-> !pwm_o);
endmodule

// File: tb/pwm_carrier_tb.sv
module pwm_carrier_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b1;
  logic       tmr_run_i = 1'b1;
  logic [1:0] presc_sel_i = 2'd0;
  logic [7:0] period_i = 8'd0;
  logic [7:0] duty_hi_i = 8'd0;
  logic [3:0] ctrl_i = 4'd0;
  logic       pwm_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  pwm_carrier u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .tmr_run_i   (tmr_run_i),
    .presc_sel_i (presc_sel_i),
    .period_i    (period_i),
    .duty_hi_i   (duty_hi_i),
    .ctrl_i      (ctrl_i),
    .pwm_o       (pwm_o)
  );

  // period, duty_hi, duty_lo, prescaler code
  localparam int NV = 9;
  localparam int V_PER [NV] = '{130, 25, 25, 25,  3, 0, 25, 255, 2};
  localparam int V_DHI [NV] = '{ 65, 12, 26,  0,  1, 0, 12, 255, 3};
  localparam int V_DLO [NV] = '{  0,  2,  0,  0,  3, 1,  2,   3, 0};
  localparam int V_PSC [NV] = '{  0,  0,  0,  0,  1, 0,  2,   0, 3};

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic configure(int per, int dhi, int dlo, int psc, bit en);
    rst_ni = 1'b0;
    tick_i = 1'b1;
    tmr_run_i = 1'b1;
    period_i = 8'(per);
    duty_hi_i = 8'(dhi);
    presc_sel_i = 2'(psc);
    ctrl_i = {2'(dlo), en ? 2'b11 : 2'b00};
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic int ratio(int psc);
    return (psc == 0) ? 1 : (psc == 1) ? 4 : 16;
  endfunction

  task automatic count_high(int n, output int hi, output int rises);
    bit prev;
    prev = pwm_o;
    hi = 0;
    rises = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      if (pwm_o) hi++;
      if (pwm_o && !prev) rises++;
      prev = pwm_o;
    end
  endtask

  task automatic wait_level(bit lvl);
    for (int k = 0; k < 5000; k++) begin
      if (pwm_o == lvl) break;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi, rises, len, d, full, exp_h, exp_r;
    // R8 reset state
    repeat (3) @(negedge clk_i);
    check("R8 output low in reset", int'(pwm_o), 0);

    // R1 R2 R3 R4 vector walk: two whole periods per vector
    for (int i = 0; i < NV; i++) begin
      configure(V_PER[i], V_DHI[i], V_DLO[i], V_PSC[i], 1'b1);
      len   = ratio(V_PSC[i]) * 4 * (V_PER[i] + 1);
      d     = V_DHI[i] * 4 + V_DLO[i];
      full  = 4 * (V_PER[i] + 1);
      exp_h = ratio(V_PSC[i]) * ((d < full) ? d : full);
      exp_r = (exp_h > 0 && exp_h < len) ? 2 : 0;
      repeat (2 * len) @(negedge clk_i);
      count_high(2 * len, hi, rises);
      check($sformatf("R3 R4 vec%0d high samples", i), hi, 2 * exp_h);
      check($sformatf("R1 R2 vec%0d period starts", i), rises, exp_r);
    end

    // R5 clearing control forces low from a high level
    configure(130, 65, 0, 0, 1'b1);
    repeat (600) @(negedge clk_i);
    wait_level(1'b1);
    check("R5 level high before clear", int'(pwm_o), 1);
    ctrl_i = 4'd0;
    @(negedge clk_i);
    check("R5 low one clock after clear", int'(pwm_o), 0);
    count_high(600, hi, rises);
    check("R5 stays low while cleared", hi, 0);

    // R5 non-PWM mode code keeps pin low
    ctrl_i = 4'b0010;
    count_high(600, hi, rises);
    check("R5 mode 2'b10 keeps pin low", hi, 0);

    // R6 duty write at position 0 waits for the next rollover
    configure(25, 12, 2, 0, 1'b1);
    repeat (300) @(negedge clk_i);
    wait_level(1'b0);
    wait_level(1'b1);
    duty_hi_i = 8'd20;
    ctrl_i = 4'b0011;
    hi = 1;
    for (int k = 1; k < 104; k++) begin
      @(negedge clk_i);
      if (pwm_o) hi++;
    end
    check("R6 old duty holds for current period", hi, 50);
    count_high(104, hi, rises);
    check("R6 new duty after rollover", hi, 80);

    // R7 stalls hold the level
    configure(25, 12, 2, 0, 1'b1);
    repeat (300) @(negedge clk_i);
    wait_level(1'b1);
    tick_i = 1'b0;
    count_high(50, hi, rises);
    check("R7 tick low holds high level", hi, 50);
    tick_i = 1'b1;
    wait_level(1'b0);
    tmr_run_i = 1'b0;
    count_high(200, hi, rises);
    check("R7 run low holds low level", hi, 0);
    tmr_run_i = 1'b1;
    count_high(208, hi, rises);
    check("R7 resumes after run restored", hi, 100);

    // R8 reset mid-run returns pin low
    wait_level(1'b1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8 async reset forces low", int'(pwm_o), 0);
    rst_ni = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule